// File: doc/BRIEF.md
# Configurable Two-Port RAM

A parameterized simple two-port memory with one write port and one read port. The two ports may share one clock or run on separate write and read clocks. The active edge of each clock is chosen as rising or falling. Write and read widths and depths are set independently, so a wide write port can feed a narrow read port, or the other way round, as long as both sides describe the same total number of bits.

Every control input uses one of three modes: active-low, active-high, or tied off, in which case the pin is ignored. Mode 0 means active-low, mode 1 active-high and mode 2 tied off. The write port can optionally take byte enables. The read data can optionally pass through one extra register stage. That stage has its own load enable, a synchronous clear and an asynchronous clear.

Top module: `tp_ram_wrap`

## Requirements
- R1: With the write-enable mode at 0, a write takes place on an active write-clock edge only while `wr_en` is low. A write presented with `wr_en` high leaves the memory unchanged.
- R2: With the read-enable mode at 1 and `rd_en` low, the array read register holds its value. `rd_data` does not change, whatever `rd_addr` does.
- R3: When the write word is wider than the read word by a power-of-two ratio N, read address N*a+k returns bits [k*RW+RW-1 : k*RW] of write word a, so lower read addresses map to less significant slices. The write width times the write depth must equal the read width times the read depth.
- R4: With byte enables on, a lane is 9 bits when the write width is a multiple of 9 and 8 bits otherwise. Bit i of `wr_be` gates lane i, covering write bits [i*L+L-1 : i*L], and a disabled lane keeps its old contents. With byte enables off, `wr_be` is ignored and whole words are written.
- R5: In bypass mode, read data appears after one active read-clock edge following the presentation of the address. In pipeline mode it appears after two.
- R6: In pipeline mode, while the output enable is inactive, `rd_data` holds its value.
- R7: In pipeline mode, an active synchronous clear sets `rd_data` to zero at the next read-clock edge, even while the output enable is inactive.
- R8: In pipeline mode, an active asynchronous clear forces `rd_data` to zero without waiting for a clock edge. It keeps `rd_data` at zero across edges, whatever the state of the synchronous clear and the output enable.
- R9: On a shared clock, a read of a location written on the same edge returns the contents from before the write.
- R10: A control whose mode is 2 ignores its pin. The read enable then behaves as always active, and the write enable behaves as always active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write clock; also the shared clock when CLK_COUNT is 1 |
| clk_rd | input | 1 | Read clock, used only when CLK_COUNT is 2 |
| wr_en | input | 1 | Write enable, polarity per WEN_MODE |
| wr_addr | input | WAW | Write word address |
| wr_data | input | WR_WIDTH | Write data |
| wr_be | input | BEW | Write lane enables, active high (used only when BYTE_EN is 1) |
| rd_en | input | 1 | Read enable, polarity per REN_MODE |
| rd_addr | input | RAW | Read word address |
| rd_data | output | RD_WIDTH | Read data |
| out_en | input | 1 | Output register load enable, polarity per OEN_MODE |
| out_srst | input | 1 | Output register synchronous clear, polarity per SRST_MODE |
| out_arst | input | 1 | Output register asynchronous clear, polarity per ARST_MODE |

## Verification
The bench builds two instances. The first uses a shared clock, an 18-bit by 64 write side over a 9-bit by 128 read side, byte enables, and the pipeline stage. In that instance the write enable is active-low, the read enable and output enable are active-high, the synchronous clear is active-low and the asynchronous clear is active-high. This brings the slice mapping, lane masking, both polarities, clear priorities and same-edge read-before-write within reach. The second instance keeps the default equal widths, bypass output and tied-off read enable on a 16-word array. It drives the ignored pins to their "wrong" levels to show that they have no effect, and it measures the one-edge bypass latency.

// File: rtl/tpr_pkg.sv
`timescale 1ns/1ps
// Package tpr_pkg
// Shared mode codes and the control-pin decode used by the two-port RAM
// wrapper. Assumes every mode parameter is one of the three codes below.
package tpr_pkg;
    localparam int MODE_LOW  = 0;
    localparam int MODE_HIGH = 1;
    localparam int MODE_TIED = 2;

    // Turn a raw pin into an active-high function flag for a given mode.
    function automatic logic ctl_act(input int mode, input logic pin, input logic idle);
        if (mode == MODE_LOW)       return ~pin;
        else if (mode == MODE_HIGH) return pin;
        else                        return idle;
    endfunction
endpackage

// File: rtl/tpr_pol.sv
`timescale 1ns/1ps
// Module tpr_pol
// Decodes one control pin into an active-high flag according to its
// three-way mode. In the tied-off mode the pin is ignored and the flag
// takes the constant IDLE level. Purely combinational.
module tpr_pol
    import tpr_pkg::*;
#(
    parameter int   MODE = MODE_HIGH,
    parameter logic IDLE = 1'b1
) (
    input  logic pin,
    output logic act
);
    // Mode decode of the raw pin.
    assign act = ctl_act(MODE, pin, IDLE);
endmodule

// File: rtl/tpr_mem_core.sv
`timescale 1ns/1ps
// Module tpr_mem_core
// Storage array held as write-side words, with a lane-masked write port
// and a registered read port of a different width. Assumes the width
// ratio is a power of two and WW*WD == RW*RD. A read and a write of the
// same word on the same edge return the old data.
module tpr_mem_core #(
    parameter int WW   = 18,
    parameter int WD   = 1024,
    parameter int RW   = 18,
    parameter int RD   = 1024,
    parameter int LANE = 9,
    localparam int NL   = WW / LANE,
    localparam int WAW  = (WD > 1) ? $clog2(WD) : 1,
    localparam int RAW  = (RD > 1) ? $clog2(RD) : 1
) (
    input  logic           wclk,
    input  logic           we,
    input  logic [WAW-1:0] waddr,
    input  logic [WW-1:0]  wdata,
    input  logic [NL-1:0]  be,
    input  logic           rclk,
    input  logic           re,
    input  logic [RAW-1:0] raddr,
    output logic [RW-1:0]  q
);
    localparam int RATIO = (RW > WW) ? RW / WW : WW / RW;
    localparam int SELW  = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [WW-1:0] mem [WD];

    // Lane-masked write of one write-side word.
    always_ff @(posedge wclk) begin
        if (we) begin
            for (int l = 0; l < NL; l++) begin
                if (be[l]) mem[waddr][l*LANE +: LANE] <= wdata[l*LANE +: LANE];
            end
        end
    end

    generate
        if (RW == WW) begin : g_same
            // Equal widths: read the addressed word directly.
            always_ff @(posedge rclk) begin
                if (re) q <= mem[raddr];
            end
        end else if (RW < WW) begin : g_narrow
            logic [WW-1:0]   word;
            logic [SELW-1:0] sel;
            // Pick the containing write word and the slice number.
            always_comb begin
                word = mem[raddr[RAW-1:SELW]];
                sel  = raddr[SELW-1:0];
            end
            // Register the selected slice, low addresses in low bits.
            always_ff @(posedge rclk) begin
                if (re) q <= RW'(word >> (RW * int'(sel)));
            end
        end else begin : g_wide
            // Gather RATIO consecutive write words, lowest word in low bits.
            always_ff @(posedge rclk) begin
                if (re) begin
                    for (int k = 0; k < RATIO; k++) begin
                        q[k*WW +: WW] <= mem[{raddr, SELW'(k)}];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tpr_out_reg.sv
`timescale 1ns/1ps
// Module tpr_out_reg
// Optional pipeline stage on the read data. Priority: asynchronous
// clear, then synchronous clear, then load enable. ASYNC selects whether
// the asynchronous clear is wired at all. Assumes active-high inputs.
module tpr_out_reg #(
    parameter int W     = 18,
    parameter bit ASYNC = 1'b0
) (
    input  logic         clk,
    input  logic         arst,
    input  logic         srst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (ASYNC) begin : g_async
            // Register with asynchronous clear over synchronous clear.
            always_ff @(posedge clk or posedge arst) begin
                if (arst)      q <= '0;
                else if (srst) q <= '0;
                else if (en)   q <= d;
            end
        end else begin : g_sync
            logic unused_arst;
            assign unused_arst = arst;
            // Register with synchronous clear only.
            always_ff @(posedge clk) begin
                if (srst)    q <= '0;
                else if (en) q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/tp_ram_wrap.sv
`timescale 1ns/1ps
// Module tp_ram_wrap
// Configurable two-port RAM: shared or split clocks with selectable
// edges, three-way control polarities, optional lane enables and an
// optional read output register. Assumes WR_WIDTH*WR_DEPTH equals
// RD_WIDTH*RD_DEPTH with a power-of-two width ratio.
module tp_ram_wrap
    import tpr_pkg::*;
#(
    parameter int CLK_COUNT = 1,
    parameter bit WCLK_FALL = 1'b0,
    parameter bit RCLK_FALL = 1'b0,
    parameter int WR_WIDTH  = 18,
    parameter int WR_DEPTH  = 1024,
    parameter int RD_WIDTH  = 18,
    parameter int RD_DEPTH  = 1024,
    parameter int WEN_MODE  = MODE_HIGH,
    parameter int REN_MODE  = MODE_TIED,
    parameter bit OUT_PIPE  = 1'b0,
    parameter int OEN_MODE  = MODE_TIED,
    parameter int SRST_MODE = MODE_TIED,
    parameter int ARST_MODE = MODE_TIED,
    parameter bit BYTE_EN   = 1'b0,
    localparam int WAW  = (WR_DEPTH > 1) ? $clog2(WR_DEPTH) : 1,
    localparam int RAW  = (RD_DEPTH > 1) ? $clog2(RD_DEPTH) : 1,
    localparam int LANE = (WR_WIDTH % 9 == 0) ? 9 : ((WR_WIDTH % 8 == 0) ? 8 : WR_WIDTH),
    localparam int NL   = WR_WIDTH / LANE,
    localparam int BEW  = BYTE_EN ? NL : 1
) (
    input  logic                clk_wr,
    input  logic                clk_rd,
    input  logic                wr_en,
    input  logic [WAW-1:0]      wr_addr,
    input  logic [WR_WIDTH-1:0] wr_data,
    input  logic [BEW-1:0]      wr_be,
    input  logic                rd_en,
    input  logic [RAW-1:0]      rd_addr,
    output logic [RD_WIDTH-1:0] rd_data,
    input  logic                out_en,
    input  logic                out_srst,
    input  logic                out_arst
);
    localparam bit RFALL = (CLK_COUNT == 2) ? RCLK_FALL : WCLK_FALL;

    logic wclk, rclk;
    logic we_a, ren_a, oen_a, srst_a, arst_a;
    logic [NL-1:0]       lanes;
    logic [RD_WIDTH-1:0] core_q;

    // Clock selection and edge inversion.
    assign wclk = clk_wr ^ WCLK_FALL;
    assign rclk = ((CLK_COUNT == 2) ? clk_rd : clk_wr) ^ RFALL;

    tpr_pol #(.MODE(WEN_MODE),  .IDLE(1'b1)) u_we   (.pin(wr_en),    .act(we_a));
    tpr_pol #(.MODE(REN_MODE),  .IDLE(1'b1)) u_re   (.pin(rd_en),    .act(ren_a));
    tpr_pol #(.MODE(OEN_MODE),  .IDLE(1'b1)) u_oen  (.pin(out_en),   .act(oen_a));
    tpr_pol #(.MODE(SRST_MODE), .IDLE(1'b0)) u_srst (.pin(out_srst), .act(srst_a));
    tpr_pol #(.MODE(ARST_MODE), .IDLE(1'b0)) u_arst (.pin(out_arst), .act(arst_a));

    generate
        if (BYTE_EN) begin : g_be
            // Lane enables come straight from the port.
            assign lanes = wr_be;
        end else begin : g_nobe
            logic unused_be;
            assign unused_be = ^wr_be;
            // Whole-word writes.
            assign lanes = '1;
        end
    endgenerate

    tpr_mem_core #(
        .WW(WR_WIDTH), .WD(WR_DEPTH), .RW(RD_WIDTH), .RD(RD_DEPTH), .LANE(LANE)
    ) u_core (
        .wclk(wclk), .we(we_a), .waddr(wr_addr), .wdata(wr_data), .be(lanes),
        .rclk(rclk), .re(ren_a), .raddr(rd_addr), .q(core_q)
    );

    generate
        if (OUT_PIPE) begin : g_pipe
            tpr_out_reg #(.W(RD_WIDTH), .ASYNC(ARST_MODE != MODE_TIED)) u_oreg (
                .clk(rclk), .arst(arst_a), .srst(srst_a), .en(oen_a),
                .d(core_q), .q(rd_data)
            );
        end else begin : g_bypass
            // Bypass: array read register drives the output.
            assign rd_data = core_q;
        end
    endgenerate
endmodule

// File: rtl/tpr_chk.sv
`timescale 1ns/1ps
// Module tpr_chk
// Assertion checker bound into every tp_ram_wrap instance. Watches the
// decoded control flags, the array read register and the output.
module tpr_chk #(
    parameter int WW   = 18,
    parameter int WD   = 1024,
    parameter int RW   = 18,
    parameter int RD   = 1024,
    parameter bit PIPE = 1'b0
) (
    input logic          rclk,
    input logic          ren_a,
    input logic          oen_a,
    input logic          srst_a,
    input logic          arst_a,
    input logic [RW-1:0] core_q,
    input logic [RW-1:0] rd_data
);
    logic armed = 1'b0;
    // Marks that at least one read edge has passed.
    always_ff @(posedge rclk) armed <= 1'b1;

    // Both sides must describe the same storage (R3).
    initial begin
        p_storage_match_r3: assert (WW * WD == RW * RD)
            else $error("write and read storage sizes differ");
    end

    // Read disabled: array read register holds (R2).
    p_read_hold_r2: assert property (@(posedge rclk) disable iff (!armed)
        !ren_a |=> $stable(core_q));

    generate
        if (PIPE) begin : g_pipe_chk
            // Output enable low and no clear: output holds (R6).
            p_out_hold_r6: assert property (@(posedge rclk) disable iff (!armed || arst_a)
                (!srst_a && !oen_a) |=> $stable(rd_data));
            // Synchronous clear empties the output on the next edge (R7).
            p_sync_clear_r7: assert property (@(posedge rclk) disable iff (!armed || arst_a)
                srst_a |=> (rd_data == '0));
            // Asynchronous clear keeps the output at zero (R8).
            p_async_clear_r8: assert property (@(posedge rclk) disable iff (!armed)
                arst_a |-> (rd_data == '0));
        end
    endgenerate
endmodule

bind tp_ram_wrap tpr_chk #(
    .WW(WR_WIDTH), .WD(WR_DEPTH), .RW(RD_WIDTH), .RD(RD_DEPTH), .PIPE(OUT_PIPE)
) u_chk (
    .rclk(rclk), .ren_a(ren_a), .oen_a(oen_a), .srst_a(srst_a),
    .arst_a(arst_a), .core_q(core_q), .rd_data(rd_data)
);

// File: tb/sim_tp_ram_wrap.sv
`timescale 1ns/1ps
// Directed bench for tp_ram_wrap: u0 is a pipelined 18->9 instance with
// lane enables and mixed polarities, u1 a default-style bypass instance.
module sim_tp_ram_wrap;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_cmp = 0;
    int n_bad = 0;

    // u0 signals
    logic       a_wen_n = 1'b1;
    logic [5:0] a_waddr = '0;
    logic [17:0] a_wdata = '0;
    logic [1:0] a_be = 2'b11;
    logic       a_ren = 1'b1;
    logic [6:0] a_raddr = '0;
    logic [8:0] a_rdata;
    logic       a_oen = 1'b1;
    logic       a_srst_n = 1'b1;
    logic       a_arst = 1'b1;

    // u1 signals
    logic       b_we = 1'b0;
    logic [3:0] b_waddr = '0;
    logic [17:0] b_wdata = '0;
    logic [0:0] b_be = 1'b0;
    logic       b_ren = 1'b0;
    logic [3:0] b_raddr = '0;
    logic [17:0] b_rdata;
    logic       b_oen = 1'b0;
    logic       b_srst = 1'b1;
    logic       b_arst = 1'b1;

    tp_ram_wrap #(
        .CLK_COUNT(1), .WR_WIDTH(18), .WR_DEPTH(64), .RD_WIDTH(9), .RD_DEPTH(128),
        .WEN_MODE(0), .REN_MODE(1), .OUT_PIPE(1'b1), .OEN_MODE(1),
        .SRST_MODE(0), .ARST_MODE(1), .BYTE_EN(1'b1)
    ) u0 (
        .clk_wr(clk), .clk_rd(clk), .wr_en(a_wen_n), .wr_addr(a_waddr),
        .wr_data(a_wdata), .wr_be(a_be), .rd_en(a_ren), .rd_addr(a_raddr),
        .rd_data(a_rdata), .out_en(a_oen), .out_srst(a_srst_n), .out_arst(a_arst)
    );

    tp_ram_wrap #(
        .WR_DEPTH(16), .RD_DEPTH(16)
    ) u1 (
        .clk_wr(clk), .clk_rd(clk), .wr_en(b_we), .wr_addr(b_waddr),
        .wr_data(b_wdata), .wr_be(b_be), .rd_en(b_ren), .rd_addr(b_raddr),
        .rd_data(b_rdata), .out_en(b_oen), .out_srst(b_srst), .out_arst(b_arst)
    );

    function automatic logic [8:0] lo_of(input int i);
        return 9'(i * 37 + 1);
    endfunction
    function automatic logic [8:0] hi_of(input int i);
        return 9'(i * 53 + 100);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic a_write(input logic [5:0] ad, input logic [17:0] d, input logic [1:0] be);
        @(negedge clk);
        a_waddr = ad; a_wdata = d; a_be = be; a_wen_n = 1'b0;
        @(negedge clk);
        a_wen_n = 1'b1;
    endtask

    task automatic a_read(input logic [6:0] ad, output logic [8:0] v);
        @(negedge clk);
        a_raddr = ad;
        @(negedge clk);
        @(negedge clk);
        v = a_rdata;
    endtask

    // Reset state: async clear held from time zero (R8).
    task automatic t_reset;
        @(negedge clk);
        check("R8 reset state", 32'(a_rdata), 32'h0);
        a_arst = 1'b0;
    endtask

    // Slice mapping of 18-bit words onto 9-bit reads (R3).
    task automatic t_slices;
        logic [8:0] v;
        for (int i = 0; i < 8; i++) a_write(6'(i), {hi_of(i), lo_of(i)}, 2'b11);
        for (int i = 0; i < 8; i++) begin
            a_read(7'(2 * i), v);
            check("R3 low slice", 32'(v), 32'(lo_of(i)));
            a_read(7'(2 * i + 1), v);
            check("R3 high slice", 32'(v), 32'(hi_of(i)));
        end
    endtask

    // Active-low write enable: pin high blocks the write (R1).
    task automatic t_wen_low;
        logic [8:0] v;
        @(negedge clk);
        a_waddr = 6'd3; a_wdata = 18'h3FFFF; a_be = 2'b11; a_wen_n = 1'b1;
        @(negedge clk);
        a_read(7'd6, v);
        check("R1 blocked write", 32'(v), 32'(lo_of(3)));
    endtask

    // Lane enable masks the low lane (R4).
    task automatic t_lanes;
        logic [8:0] v;
        a_write(6'd4, {9'h155, 9'h0AA}, 2'b10);
        a_read(7'd8, v);
        check("R4 masked lane kept", 32'(v), 32'(lo_of(4)));
        a_read(7'd9, v);
        check("R4 enabled lane written", 32'(v), 32'h155);
    endtask

    // Pipeline latency of two edges (R5).
    task automatic t_latency;
        @(negedge clk);
        a_raddr = 7'd0;
        @(negedge clk);
        check("R5 not after one edge", 32'(a_rdata), 32'h155);
        @(negedge clk);
        check("R5 after two edges", 32'(a_rdata), 32'(lo_of(0)));
    endtask

    // Read enable low holds the data; high resumes (R2).
    task automatic t_ren;
        logic [8:0] v;
        @(negedge clk);
        a_ren = 1'b0; a_raddr = 7'd2;
        repeat (3) @(negedge clk);
        check("R2 read hold", 32'(a_rdata), 32'(lo_of(0)));
        a_ren = 1'b1;
        a_read(7'd2, v);
        check("R2 read resumes", 32'(v), 32'(lo_of(1)));
    endtask

    // Output enable low holds the output (R6).
    task automatic t_oen;
        @(negedge clk);
        a_oen = 1'b0; a_raddr = 7'd3;
        repeat (3) @(negedge clk);
        check("R6 output hold", 32'(a_rdata), 32'(lo_of(1)));
        a_oen = 1'b1;
        @(negedge clk);
        check("R6 output loads", 32'(a_rdata), 32'(hi_of(1)));
    endtask

    // Sync clear wins over a disabled enable (R7).
    task automatic t_srst;
        @(negedge clk);
        a_oen = 1'b0; a_srst_n = 1'b0;
        @(negedge clk);
        check("R7 sync clear", 32'(a_rdata), 32'h0);
        a_srst_n = 1'b1;
        @(negedge clk);
        check("R7 stays clear", 32'(a_rdata), 32'h0);
        a_oen = 1'b1;
        @(negedge clk);
        check("R7 reload", 32'(a_rdata), 32'(hi_of(1)));
    endtask

    // Async clear acts without an edge and beats load (R8).
    task automatic t_arst;
        @(negedge clk);
        a_arst = 1'b1;
        #1;
        check("R8 async clear", 32'(a_rdata), 32'h0);
        @(negedge clk);
        check("R8 held over edge", 32'(a_rdata), 32'h0);
        a_arst = 1'b0;
        @(negedge clk);
        check("R8 release", 32'(a_rdata), 32'(hi_of(1)));
    endtask

    // Same-edge read and write return the old data (R9).
    task automatic t_rbw;
        @(negedge clk);
        a_raddr = 7'd2; a_waddr = 6'd1; a_wdata = 18'h1_2345; a_be = 2'b11; a_wen_n = 1'b0;
        @(negedge clk);
        a_wen_n = 1'b1;
        @(negedge clk);
        check("R9 old data", 32'(a_rdata), 32'(lo_of(1)));
        @(negedge clk);
        check("R9 new data next", 32'(a_rdata), 32'h145);
    endtask

    // Tied-off controls ignored, bypass latency one edge (R10, R5, R4).
    task automatic t_tied;
        @(negedge clk);
        b_we = 1'b1; b_waddr = 4'd7; b_wdata = 18'h2B5C3; b_be = 1'b0;
        @(negedge clk);
        b_we = 1'b0;
        b_raddr = 4'd7;
        @(negedge clk);
        check("R10 tied read enable / R4 full word", 32'(b_rdata), 32'h2B5C3);
        b_we = 1'b1; b_waddr = 4'd9; b_wdata = 18'h0_1111;
        @(negedge clk);
        b_we = 1'b0;
        b_raddr = 4'd9;
        @(negedge clk);
        check("R5 bypass one edge", 32'(b_rdata), 32'h0_1111);
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_slices();
        t_wen_low();
        t_lanes();
        t_latency();
        t_ren();
        t_oen();
        t_srst();
        t_arst();
        t_rbw();
        t_tied();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule